// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block merges the level-sensitive INTA to INTD pins of several PCI slots onto the sixteen inputs of a legacy interrupt controller. Each device pin is first rotated by the slot's device number onto one of four shared interrupt lanes. The pin of slot `s`, pin `p`, lands on lane `(p + FIRST_DEV + s - 1) mod 4`. The level of each lane is then steered to one legacy IRQ line by a per-lane route register.

The four route registers sit behind a byte-wide port with a 2-bit index. Every route that names the same IRQ contributes to it by OR. A route value of 16 or more parks its lane, so that lane drives nothing. The sixteen outputs are combinational in the pins and the stored routes. A parameter selects between two reset profiles for the route registers.

Top module: `pirq_router`

## Requirements
- R1: Pin `p` (0 = INTA .. 3 = INTD) of slot `s` in bit `4*s+p` of `int_pins` feeds lane `(p + FIRST_DEV + s - 1) mod 4`, with FIRST_DEV = 1 by default.
- R2: A lane's level is the OR of every slot pin that rotates onto it, and no IRQ output is high while all pins are low.
- R3: A route value of 0 to 15 drives IRQ output bit equal to that value with the lane's level.
- R4: A route value with bit 7 set drives no output, whatever bits 6:0 hold.
- R5: A route value of 16 to 127 also drives no output.
- R6: An IRQ output is the OR of all lanes whose route selects it, so at most four outputs are high at once.
- R7: At reset, with RST_PROFILE = 0, all four routes read 0x80. With RST_PROFILE = 1, lanes 0 and 1 read 0x0A and lanes 2 and 3 read 0x0B.
- R8: A write with `cfg_we` high stores `cfg_wdata` at `cfg_idx` on the clock edge. `cfg_rdata` always shows the stored byte at `cfg_idx`, unchanged, and a new value is used for routing from the next cycle.
- R9: The outputs follow the pins in the same cycle, with no register between pins and `irq_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the route registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pins | input | 4*NSLOT | Slot interrupt pins, four per slot, INTA at the lowest bit |
| cfg_idx | input | 2 | Route register index |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Stored byte at `cfg_idx` |
| irq_lvl | output | 16 | Level vector to the interrupt controller |

## Verification
A pin change is due on `irq_lvl` in the same cycle, because the path has no register. A route write is due on `cfg_rdata` and on the routing one edge after the strobe. The bench drives inputs shortly after each rising edge and updates its behavioural model on that edge. It compares both outputs at the falling edge of every cycle, so each result is sampled in the cycle it is due.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NSLOT       = 4,
  parameter int FIRST_DEV   = 1,
  parameter int RST_PROFILE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4*NSLOT-1:0] int_pins,
  input  logic [1:0]         cfg_idx,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic [15:0]        irq_lvl
);
  localparam int NLANE = 4;
  localparam int NIRQ  = 16;

  function automatic logic [7:0] rst_route(input int lane);
    if (RST_PROFILE == 1) return (lane < 2) ? 8'h0A : 8'h0B;
    return 8'h80;
  endfunction

  logic [7:0]       route_q [NLANE];
  logic [NLANE-1:0] lane_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NLANE; q++) route_q[q] <= rst_route(q);
    end else if (cfg_we) begin
      route_q[cfg_idx] <= cfg_wdata;
    end
  end

  assign cfg_rdata = route_q[cfg_idx];

  always_comb begin
    lane_lvl = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < 4; p++)
        lane_lvl[(p + FIRST_DEV + s - 1) % NLANE] =
          lane_lvl[(p + FIRST_DEV + s - 1) % NLANE] | int_pins[4*s+p];
  end

  always_comb begin
    irq_lvl = '0;
    for (int q = 0; q < NLANE; q++)
      if (route_q[q][7:4] == 4'd0)
        irq_lvl[route_q[q][3:0]] = irq_lvl[route_q[q][3:0]] | lane_lvl[q];
  end
endmodule

module pirq_router_chk #(
  parameter int NSLOT       = 4,
  parameter int RST_PROFILE = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4*NSLOT-1:0] int_pins,
  input logic [1:0]         cfg_idx,
  input logic               cfg_we,
  input logic [7:0]         cfg_wdata,
  input logic [7:0]         cfg_rdata,
  input logic [15:0]        irq_lvl,
  input logic [7:0]         route_q [4]
);
  a_r8_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_idx != $past(cfg_idx)) || (cfg_rdata == $past(cfg_wdata)));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pins == '0) |-> (irq_lvl == '0));

  a_r6_at_most_four: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_lvl) <= 4);

  a_r5_all_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ((route_q[0][7:4] != 0) && (route_q[1][7:4] != 0) &&
     (route_q[2][7:4] != 0) && (route_q[3][7:4] != 0)) |-> (irq_lvl == '0));

  a_r7_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |->
      ((RST_PROFILE == 1) ?
        (route_q[0] == 8'h0A && route_q[1] == 8'h0A && route_q[2] == 8'h0B && route_q[3] == 8'h0B) :
        (route_q[0] == 8'h80 && route_q[1] == 8'h80 && route_q[2] == 8'h80 && route_q[3] == 8'h80)));
endmodule

bind pirq_router pirq_router_chk #(.NSLOT(NSLOT), .RST_PROFILE(RST_PROFILE)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_pins(int_pins), .cfg_idx(cfg_idx), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_lvl(irq_lvl), .route_q(route_q)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  localparam int CLK_P = 10;
  localparam int NSLOT = 4;
  localparam int FIRST_DEV = 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [4*NSLOT-1:0] int_pins = '0;
  logic [1:0]         cfg_idx = '0;
  logic               cfg_we = 1'b0;
  logic [7:0]         cfg_wdata = '0;
  logic [7:0]         cfg_rdata, alt_rdata;
  logic [15:0]        irq_lvl, alt_irq;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R7";
  int mreg [4];

  always #(CLK_P/2) clk = ~clk;

  pirq_router #(.NSLOT(NSLOT), .FIRST_DEV(FIRST_DEV), .RST_PROFILE(0)) dut (
    .clk(clk), .rst_n(rst_n), .int_pins(int_pins), .cfg_idx(cfg_idx), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_lvl(irq_lvl));

  pirq_router #(.NSLOT(NSLOT), .FIRST_DEV(FIRST_DEV), .RST_PROFILE(1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .int_pins('0), .cfg_idx(cfg_idx), .cfg_we(1'b0),
    .cfg_wdata('0), .cfg_rdata(alt_rdata), .irq_lvl(alt_irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int q = 0; q < 4; q++) mreg[q] = 'h80;
    else if (cfg_we) mreg[cfg_idx] = cfg_wdata;
  end

  function automatic logic [15:0] model_irq();
    bit [3:0] lane;
    logic [15:0] r;
    lane = '0;
    r = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < 4; p++)
        if (int_pins[4*s+p]) lane[(p + FIRST_DEV + s - 1) % 4] = 1'b1;
    for (int q = 0; q < 4; q++)
      if (mreg[q] < 16 && lane[q]) r[mreg[q]] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, "irq_lvl", irq_lvl, model_irq());
    check((cur_req == "R7") ? "R7" : "R8", "cfg_rdata", {8'h00, cfg_rdata}, 16'(mreg[cfg_idx]));
    if (cur_req == "R7")
      check("R7", "alt cfg_rdata", {8'h00, alt_rdata}, (cfg_idx < 2) ? 16'h000A : 16'h000B);
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(int idx, int val);
    step();
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = 8'(val);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cur_req = "R7";
    for (int i = 0; i < 4; i++) begin cfg_idx = 2'(i); step(); end
    step();
    cur_req = "R1";
    wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 4);
    for (int b = 0; b < 4*NSLOT; b++) begin int_pins = 16'(1 << b); step(); end
    cur_req = "R2";
    int_pins = 16'h8421; step();
    int_pins = 16'h1248; step();
    int_pins = 16'hFFFF; step();
    int_pins = 16'h0000; step();
    int_pins = 16'h0F00; step();
    cur_req = "R3";
    for (int v = 0; v < 16; v++) begin
      wr(0, v); wr(1, 15 - v);
      int_pins = 16'h0001; step();
      int_pins = 16'hFFFF; step();
    end
    cur_req = "R4";
    int_pins = 16'hFFFF;
    wr(0, 'h80); wr(1, 'h85); wr(2, 'hFF); wr(3, 'h8B); step();
    wr(2, 'h03); step();
    cur_req = "R5";
    wr(0, 'h10); wr(1, 'h4F); wr(3, 'h7F); step();
    wr(2, 'h20); step();
    cur_req = "R6";
    for (int q = 0; q < 4; q++) wr(q, 5);
    for (int b = 0; b < 4*NSLOT; b++) begin int_pins = 16'(1 << b); step(); end
    wr(1, 9); int_pins = 16'hFFFF; step();
    cur_req = "R8";
    wr(0, 'h3C); wr(1, 'hA5); wr(2, 'h10); wr(3, 'hFF);
    for (int i = 0; i < 4; i++) begin cfg_idx = 2'(i); step(); end
    cur_req = "R9";
    wr(0, 2); wr(1, 7); wr(2, 7); wr(3, 14);
    for (int k = 0; k < 40; k++) begin int_pins = 16'((k * 40503 + 7) ^ (k << 5)); step(); end
    step();
    finish_run();
  end
endmodule